// File: doc/BRIEF.md
# Operand Forwarding and Load-Use Stall Unit

This block handles data hazards in a five-stage in-order pipeline. It looks at the two source register numbers of the instruction in the execute stage. It compares them with the destination register numbers that the memory stage and the writeback stage are about to write. For each ALU operand it then produces a select code. The code tells the operand multiplexer outside this block to take the value from the register file, from the memory-stage result or from the writeback-stage result. The multiplexers themselves are outside the block.

The register file writes only on the rising clock edge. A value written back in the same cycle as a decode read is therefore not yet visible to that read. For this reason the block also produces one bypass flag for each decode read port. The flag tells decode to take the writeback value instead of the register file output.

A load cannot hand its data to the instruction directly behind it. When the execute stage holds a load whose destination is a source of the instruction in decode, the block stalls for one cycle. During that cycle the program counter and the fetch/decode register keep their contents, and the block requests a zero control word in the decode/execute register.

The block is purely combinational. Two parameters set its variants: the register-number width, and whether register 0 counts as a hardwired zero.

Top module: `hazard_unit`

## Requirements
- R1: With no matching destination and no pending load, both forward selects are 2'b00 (register file), both decode bypass flags are 0, pc_we and ifid_we are 1, and idex_bubble is 0.
- R2: When mem_wr is 1 and mem_dst equals an execute source register, that operand's select is 2'b10 (memory-stage result).
- R3: When wb_wr is 1, wb_dst equals an execute source register, and the memory stage does not match that register, that operand's select is 2'b01 (writeback-stage result).
- R4: When both the memory stage and the writeback stage write the same execute source register, the select is 2'b10, because the memory-stage value is younger.
- R5: A stage whose write flag is 0 is never used as a forward source. With the hardwired-zero option enabled (the default), a source register number of 0 always selects 2'b00.
- R6: The two operands are resolved independently, so operand A and operand B can take different sources in the same cycle.
- R7: When ex_load is 1 and ex_load_dst equals dec_src_a or dec_src_b, pc_we and ifid_we are 0 and idex_bubble is 1.
- R8: No stall is raised when a load's destination matches neither decode source, or when a matching instruction in execute is not a load.
- R9: dec_byp_a (and likewise dec_byp_b) is 1 exactly when wb_wr is 1, wb_dst is nonzero, and wb_dst equals dec_src_a (dec_src_b).
- R10: pc_we and ifid_we are always equal, and idex_bubble is always their inverse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_src_a | input | REG_AW | First source register of the instruction in decode |
| dec_src_b | input | REG_AW | Second source register of the instruction in decode |
| ex_src_a | input | REG_AW | First source register held in the decode/execute register |
| ex_src_b | input | REG_AW | Second source register held in the decode/execute register |
| ex_load | input | 1 | The instruction in execute reads data memory |
| ex_load_dst | input | REG_AW | Load destination register held in the decode/execute register |
| mem_wr | input | 1 | Memory-stage instruction writes a register |
| mem_dst | input | REG_AW | Memory-stage destination register |
| wb_wr | input | 1 | Writeback-stage instruction writes a register |
| wb_dst | input | REG_AW | Writeback-stage destination register |
| fwd_a | output | 2 | Operand A source: 00 regfile, 10 memory stage, 01 writeback stage |
| fwd_b | output | 2 | Operand B source, same encoding |
| dec_byp_a | output | 1 | Decode read A takes the writeback value |
| dec_byp_b | output | 1 | Decode read B takes the writeback value |
| pc_we | output | 1 | Program counter update enable |
| ifid_we | output | 1 | Fetch/decode register update enable |
| idex_bubble | output | 1 | Load a zero control word into decode/execute |

## Verification
Four properties are checked on every evaluation:
- the select codes never take the unused value 2'b11;
- a memory-stage match always wins;
- register 0 is never forwarded;
- the stall outputs stay consistent with one another, and a detected load-use pair always stalls.

Every decode bypass flag must also be justified by the writeback stage. Some behaviours can only be shown by the bench's directed scenarios:
- the writeback-stage selection;
- independent resolution of the two operands;
- the absence of a stall for non-loads and non-matching loads;
- that a cleared write flag suppresses forwarding.

// File: rtl/hz_pkg.sv
package hz_pkg;
   typedef enum logic [1:0] {
      FWD_RF  = 2'b00,
      FWD_MWB = 2'b01,
      FWD_EXM = 2'b10
   } fwd_sel_e;
endpackage

// File: rtl/hz_src_fwd.sv
// Source select for one ALU operand: the younger producer wins.
module hz_src_fwd
   import hz_pkg::*;
#(
   parameter int REG_AW     = 5,
   parameter bit ZERO_GUARD = 1'b1
) (
   input  logic [REG_AW-1:0] src,
   input  logic              exm_we,
   input  logic [REG_AW-1:0] exm_dst,
   input  logic              mwb_we,
   input  logic [REG_AW-1:0] mwb_dst,
   output fwd_sel_e          sel
);
   logic src_live;
   logic exm_hit;
   logic mwb_hit;

   generate
      if (ZERO_GUARD) begin : g_zero_guard
         assign src_live = |src;
      end else begin : g_no_guard
         assign src_live = 1'b1;
      end
   endgenerate

   assign exm_hit = exm_we && (exm_dst == src) && src_live;
   assign mwb_hit = mwb_we && (mwb_dst == src) && src_live;

   always_comb begin
      if (exm_hit)      sel = FWD_EXM;
      else if (mwb_hit) sel = FWD_MWB;
      else              sel = FWD_RF;
   end
endmodule

// File: rtl/hz_loaduse.sv
// One-cycle stall when a load feeds the very next instruction.
module hz_loaduse #(
   parameter int REG_AW = 5,
   parameter int NUM_RD = 2
) (
   input  logic              ld_pending,
   input  logic [REG_AW-1:0] ld_dst,
   input  logic [REG_AW-1:0] use_idx [NUM_RD],
   output logic              stall
);
   logic [NUM_RD-1:0] hit;

   generate
      for (genvar i = 0; i < NUM_RD; i++) begin : g_cmp
         assign hit[i] = (use_idx[i] == ld_dst);
      end
   endgenerate

   assign stall = ld_pending && (|hit);
endmodule

// File: rtl/hz_dec_byp.sv
// Decode read bypass: the regfile write lands only at the clock edge.
module hz_dec_byp #(
   parameter int REG_AW     = 5,
   parameter bit ZERO_GUARD = 1'b1
) (
   input  logic [REG_AW-1:0] rd_idx,
   input  logic              wb_we,
   input  logic [REG_AW-1:0] wb_idx,
   output logic              byp
);
   logic dst_live;

   generate
      if (ZERO_GUARD) begin : g_zero_guard
         assign dst_live = |wb_idx;
      end else begin : g_no_guard
         assign dst_live = 1'b1;
      end
   endgenerate

   assign byp = wb_we && dst_live && (wb_idx == rd_idx);
endmodule

// File: rtl/hazard_unit.sv
module hazard_unit
   import hz_pkg::*;
#(
   parameter int REG_AW     = 5,
   parameter bit ZERO_GUARD = 1'b1
) (
   input  logic [REG_AW-1:0] dec_src_a,
   input  logic [REG_AW-1:0] dec_src_b,
   input  logic [REG_AW-1:0] ex_src_a,
   input  logic [REG_AW-1:0] ex_src_b,
   input  logic              ex_load,
   input  logic [REG_AW-1:0] ex_load_dst,
   input  logic              mem_wr,
   input  logic [REG_AW-1:0] mem_dst,
   input  logic              wb_wr,
   input  logic [REG_AW-1:0] wb_dst,
   output logic [1:0]        fwd_a,
   output logic [1:0]        fwd_b,
   output logic              dec_byp_a,
   output logic              dec_byp_b,
   output logic              pc_we,
   output logic              ifid_we,
   output logic              idex_bubble
);
   localparam int NUM_OPS = 2;

   generate
      if (REG_AW < 1 || REG_AW > 8) begin : g_bad_aw
         $error("hazard_unit: REG_AW out of range 1..8");
      end
   endgenerate

   logic [REG_AW-1:0] ex_src  [NUM_OPS];
   logic [REG_AW-1:0] dec_src [NUM_OPS];
   fwd_sel_e          op_sel  [NUM_OPS];
   logic [NUM_OPS-1:0] byp;
   logic               stall;

   assign ex_src[0]  = ex_src_a;
   assign ex_src[1]  = ex_src_b;
   assign dec_src[0] = dec_src_a;
   assign dec_src[1] = dec_src_b;

   generate
      for (genvar i = 0; i < NUM_OPS; i++) begin : g_op
         hz_src_fwd #(.REG_AW(REG_AW), .ZERO_GUARD(ZERO_GUARD)) u_fwd (
            .src     (ex_src[i]),
            .exm_we  (mem_wr),
            .exm_dst (mem_dst),
            .mwb_we  (wb_wr),
            .mwb_dst (wb_dst),
            .sel     (op_sel[i])
         );
         hz_dec_byp #(.REG_AW(REG_AW), .ZERO_GUARD(ZERO_GUARD)) u_byp (
            .rd_idx (dec_src[i]),
            .wb_we  (wb_wr),
            .wb_idx (wb_dst),
            .byp    (byp[i])
         );
      end
   endgenerate

   hz_loaduse #(.REG_AW(REG_AW), .NUM_RD(NUM_OPS)) u_ld (
      .ld_pending (ex_load),
      .ld_dst     (ex_load_dst),
      .use_idx    (dec_src),
      .stall      (stall)
   );

   assign fwd_a       = op_sel[0];
   assign fwd_b       = op_sel[1];
   assign dec_byp_a   = byp[0];
   assign dec_byp_b   = byp[1];
   assign pc_we       = ~stall;
   assign ifid_we     = ~stall;
   assign idex_bubble = stall;
endmodule

// File: rtl/hazard_unit_chk.sv
module hazard_unit_chk #(
   parameter int REG_AW     = 5,
   parameter bit ZERO_GUARD = 1'b1
) (
   input logic [REG_AW-1:0] dec_src_a,
   input logic [REG_AW-1:0] dec_src_b,
   input logic [REG_AW-1:0] ex_src_a,
   input logic [REG_AW-1:0] ex_src_b,
   input logic              ex_load,
   input logic [REG_AW-1:0] ex_load_dst,
   input logic              mem_wr,
   input logic [REG_AW-1:0] mem_dst,
   input logic              wb_wr,
   input logic [REG_AW-1:0] wb_dst,
   input logic [1:0]        fwd_a,
   input logic [1:0]        fwd_b,
   input logic              dec_byp_a,
   input logic              dec_byp_b,
   input logic              pc_we,
   input logic              ifid_we,
   input logic              idex_bubble
);
   always_comb begin
      assert_legal_code_R1: assert (fwd_a != 2'b11 && fwd_b != 2'b11)
         else $error("unused forward code");
      if (mem_wr && mem_dst == ex_src_a && (!ZERO_GUARD || ex_src_a != '0))
         assert_exm_priority_R4: assert (fwd_a == 2'b10)
            else $error("memory-stage match lost on operand A");
      if (ZERO_GUARD && ex_src_b == '0)
         assert_zero_reg_R5: assert (fwd_b == 2'b00)
            else $error("register 0 forwarded on operand B");
      if (ex_load && (ex_load_dst == dec_src_a || ex_load_dst == dec_src_b))
         assert_load_use_R7: assert (idex_bubble && !pc_we)
            else $error("load-use pair not stalled");
      assert_stall_consistent_R10: assert (pc_we == ifid_we && idex_bubble == !pc_we)
         else $error("stall outputs disagree");
      if (dec_byp_a)
         assert_byp_source_R9: assert (wb_wr && wb_dst == dec_src_a)
            else $error("decode bypass without writeback match");
      if (dec_byp_b)
         assert_byp_source_b_R9: assert (wb_wr && wb_dst == dec_src_b)
            else $error("decode bypass B without writeback match");
   end
endmodule

bind hazard_unit hazard_unit_chk #(.REG_AW(REG_AW), .ZERO_GUARD(ZERO_GUARD)) u_chk (.*);

// File: tb/sim_hazard_unit.sv
module sim_hazard_unit;
   localparam int AW = 5;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic [AW-1:0] dec_src_a, dec_src_b, ex_src_a, ex_src_b, ex_load_dst, mem_dst, wb_dst;
   logic          ex_load, mem_wr, wb_wr;
   logic [1:0]    fwd_a, fwd_b;
   logic          dec_byp_a, dec_byp_b, pc_we, ifid_we, idex_bubble;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   hazard_unit #(.REG_AW(AW)) u0 (.*);

   task automatic drive(input logic [AW-1:0] da, db, ea, eb,
                        input logic ld, input logic [AW-1:0] ldd,
                        input logic mw, input logic [AW-1:0] md,
                        input logic ww, input logic [AW-1:0] wd);
      @(negedge clk);
      dec_src_a = da; dec_src_b = db; ex_src_a = ea; ex_src_b = eb;
      ex_load = ld; ex_load_dst = ldd;
      mem_wr = mw; mem_dst = md; wb_wr = ww; wb_dst = wd;
      #1;
   endtask

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic chk_stall(input string req, input bit st);
      chk(req, "pc_we", pc_we, !st);
      chk(req, "ifid_we", ifid_we, !st);
      chk(req, "idex_bubble", idex_bubble, st);
   endtask

   task automatic t_idle;   // R1
      drive(1, 2, 3, 4, 0, 9, 1, 10, 1, 11);
      chk("R1", "fwd_a", fwd_a, 0);
      chk("R1", "fwd_b", fwd_b, 0);
      chk("R1", "dec_byp_a", dec_byp_a, 0);
      chk("R1", "dec_byp_b", dec_byp_b, 0);
      chk_stall("R1", 0);
   endtask

   task automatic t_exm;    // R2
      drive(1, 2, 7, 4, 0, 0, 1, 7, 0, 0);
      chk("R2", "fwd_a", fwd_a, 2);
      chk("R2", "fwd_b", fwd_b, 0);
      drive(1, 2, 3, 7, 0, 0, 1, 7, 0, 0);
      chk("R2", "fwd_b", fwd_b, 2);
   endtask

   task automatic t_mwb;    // R3
      drive(1, 2, 12, 4, 0, 0, 1, 13, 1, 12);
      chk("R3", "fwd_a", fwd_a, 1);
      drive(1, 2, 3, 31, 0, 0, 0, 0, 1, 31);
      chk("R3", "fwd_b", fwd_b, 1);
   endtask

   task automatic t_both;   // R4
      drive(1, 2, 6, 6, 0, 0, 1, 6, 1, 6);
      chk("R4", "fwd_a", fwd_a, 2);
      chk("R4", "fwd_b", fwd_b, 2);
   endtask

   task automatic t_gate;   // R5
      drive(1, 2, 8, 9, 0, 0, 0, 8, 0, 9);
      chk("R5", "fwd_a write off", fwd_a, 0);
      chk("R5", "fwd_b write off", fwd_b, 0);
      drive(0, 0, 0, 0, 0, 5, 1, 0, 1, 0);
      chk("R5", "fwd_a reg0", fwd_a, 0);
      chk("R5", "fwd_b reg0", fwd_b, 0);
   endtask

   task automatic t_split;  // R6
      drive(1, 2, 14, 15, 0, 0, 1, 14, 1, 15);
      chk("R6", "fwd_a", fwd_a, 2);
      chk("R6", "fwd_b", fwd_b, 1);
   endtask

   task automatic t_load;   // R7
      drive(2, 5, 1, 3, 1, 2, 0, 0, 0, 0);
      chk_stall("R7", 1);
      drive(5, 2, 1, 3, 1, 2, 0, 0, 0, 0);
      chk_stall("R7", 1);
   endtask

   task automatic t_noload; // R8
      drive(2, 5, 1, 3, 1, 9, 0, 0, 0, 0);
      chk_stall("R8", 0);
      drive(2, 5, 1, 3, 0, 2, 0, 0, 0, 0);
      chk_stall("R8", 0);
   endtask

   task automatic t_byp;    // R9
      drive(20, 21, 1, 2, 0, 0, 0, 0, 1, 20);
      chk("R9", "dec_byp_a", dec_byp_a, 1);
      chk("R9", "dec_byp_b", dec_byp_b, 0);
      drive(20, 21, 1, 2, 0, 0, 0, 0, 0, 21);
      chk("R9", "dec_byp_b write off", dec_byp_b, 0);
      drive(0, 0, 1, 2, 0, 0, 0, 0, 1, 0);
      chk("R9", "dec_byp_a reg0", dec_byp_a, 0);
      chk("R9", "dec_byp_b reg0", dec_byp_b, 0);
   endtask

   task automatic t_cons;   // R10
      drive(4, 4, 4, 4, 1, 4, 1, 4, 1, 4);
      chk("R10", "pc_we==ifid_we", pc_we, ifid_we);
      chk("R10", "bubble", idex_bubble, 1);
      chk("R4", "fwd_a all match", fwd_a, 2);
      chk("R9", "dec_byp_b all match", dec_byp_b, 1);
   endtask

   initial begin
      drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      t_idle(); t_exm(); t_mwb(); t_both(); t_gate();
      t_split(); t_load(); t_noload(); t_byp(); t_cons();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=1 expected=0");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule